// File: doc/BRIEF.md
# Dual-Bank Interrupt Save Register Store

This block holds the ten machine-state save and scratch registers of a 64-bit processor core in two small RAM banks, an even bank and an odd bank. Registers that are used together sit at the same index in the two banks. A single write address therefore updates both members of a pair in one cycle, and each bank has its own read address so that two values can be fetched per cycle. The layout by index, with the even bank first and the odd bank second, is:

- index 0: save-PC / save-status
- index 1: scratch 0 / scratch 1
- index 2: scratch 2 / scratch 3
- index 3: hypervisor save-PC / hypervisor save-status
- index 4: hypervisor scratch 0 / hypervisor scratch 1

Three pipelines (execute, load/store, floating point) can each raise an interrupt. A fixed-priority arbiter picks one of them. The winner's saved program counter goes to the even bank. A status word, built by merging the winner's partial cause word into the current machine-state word, goes to the odd bank. Both writes happen in the same cycle at index 0. No multi-cycle writeback sequence is involved. The block has no state machine: every path is a single cycle through the arbiter and merge, followed by the bank registers.

Top module: `save_reg_store`

## Requirements
- R1: Writes use one shared address `wr_addr` for both banks. `wr_en_even` writes `wr_data_even` into the even bank and `wr_en_odd` writes `wr_data_odd` into the odd bank, both at the same index in the same cycle. Index 0 holds the save-PC/save-status pair and indices 1 to 4 hold the other pairs as listed above.
- R2: The even bank is read at `rd_addr_even` and the odd bank at `rd_addr_odd`, and the two addresses are independent. Read data is registered: it reflects the address presented before a rising edge and does not change before that edge.
- R3: When an index is written in a cycle and the same bank reads that index in the same cycle, the read output after the edge shows the newly written data (write-first).
- R4: A bank whose write enable is low keeps all of its entries unchanged, even while the other bank is written.
- R5: Synchronous active-high `rst` clears every entry of both banks and both read outputs to zero.
- R6: When `intr_taken` is high, the winning source's PC is written to even index 0 and the merged status word to odd index 0, both on the same edge.
- R7: The merged status word takes bits 63:31, 26:22 and 15:0 from `cur_msr`, bits 30:27 from cause bits 14:11, and bits 21:16 from cause bits 5:0.
- R8: Interrupt priority is execute, then load/store, then floating point. `intr_taken` is high when any request is high. `intr_vec` is the winner's vector, or zero when there is no request.
- R9: An interrupt replaces a normal register write issued in the same cycle. The normal write is dropped at whatever address it targeted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_addr | input | 3 | Shared write index |
| wr_en_even | input | 1 | Even bank write enable |
| wr_data_even | input | 64 | Even bank write data |
| wr_en_odd | input | 1 | Odd bank write enable |
| wr_data_odd | input | 64 | Odd bank write data |
| rd_addr_even | input | 3 | Even bank read index |
| rd_data_even | output | 64 | Registered even bank read data |
| rd_addr_odd | input | 3 | Odd bank read index |
| rd_data_odd | output | 64 | Registered odd bank read data |
| ex_intr | input | 1 | Execute pipeline interrupt request |
| ex_pc | input | 64 | Execute pipeline save-PC |
| ex_cause | input | 64 | Execute pipeline partial cause |
| ex_vec | input | 12 | Execute pipeline vector |
| ls_intr | input | 1 | Load/store interrupt request |
| ls_pc | input | 64 | Load/store save-PC |
| ls_cause | input | 64 | Load/store partial cause |
| ls_vec | input | 12 | Load/store vector |
| fp_intr | input | 1 | Floating-point interrupt request |
| fp_pc | input | 64 | Floating-point save-PC |
| fp_cause | input | 64 | Floating-point partial cause |
| fp_vec | input | 12 | Floating-point vector |
| cur_msr | input | 64 | Current machine-state word |
| intr_taken | output | 1 | An interrupt is being committed |
| intr_vec | output | 12 | Vector of the winning source |

## Verification
The bench walks a table of request combinations: single sources, all three together, the two lower-priority sources together, and none. This catches an arbiter with the wrong order, or one that mixes fields from two winners, because the saved PC or the vector would come from the wrong pipeline. All-ones and all-zero machine-state and cause words, along with mixed patterns, expose a status merge that places a cause field off by one bit or lets machine-state bits leak into the cause slots.

Directed cases cover the following:
- Reading a bank at the index being written. A read-first design would return stale data here.
- Writing one bank while the other has its enable low. This exposes an enable shared between the banks.
- An interrupt that collides with a normal write elsewhere. The normal write would otherwise corrupt that other pair.
- A mid-run reset. This exposes storage that survives reset.

// File: rtl/isr_pkg.sv
package isr_pkg;
    localparam int XLEN  = 64;
    localparam int VEC_W = 12;
    localparam int NSRC  = 3;

    // lower index wins arbitration
    localparam int SRC_EX = 0;
    localparam int SRC_LS = 1;
    localparam int SRC_FP = 2;

    // pair placement, same index in both banks
    localparam int IDX_SAVE  = 0;
    localparam int IDX_SCR01 = 1;
    localparam int IDX_SCR23 = 2;
    localparam int IDX_HSAVE = 3;
    localparam int IDX_HSCR  = 4;
    localparam int NPAIRS    = 5;

    // cause fields copied into the saved status word
    localparam int CHI_SRC_MSB = 14;
    localparam int CHI_SRC_LSB = 11;
    localparam int CHI_DST_MSB = 30;
    localparam int CHI_DST_LSB = 27;
    localparam int CLO_SRC_MSB = 5;
    localparam int CLO_SRC_LSB = 0;
    localparam int CLO_DST_MSB = 21;
    localparam int CLO_DST_LSB = 16;

    typedef struct packed {
        logic             req;
        logic [XLEN-1:0]  pc;
        logic [XLEN-1:0]  cause;
        logic [VEC_W-1:0] vec;
    } isrc_t;
endpackage

// File: rtl/intr_arbiter.sv
module intr_arbiter
    import isr_pkg::*;
(
    input  isrc_t [NSRC-1:0]  src,
    output logic  [NSRC-1:0]  grant,
    output logic              any_req,
    output logic  [XLEN-1:0]  sel_pc,
    output logic  [XLEN-1:0]  sel_cause,
    output logic  [VEC_W-1:0] sel_vec
);
    logic [NSRC:0] blocked;

    assign blocked[0] = 1'b0;

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_prio
            assign grant[g]       = src[g].req & ~blocked[g];
            assign blocked[g + 1] = blocked[g] | src[g].req;
        end
    endgenerate

    assign any_req = blocked[NSRC];

    always_comb begin
        sel_pc    = '0;
        sel_cause = '0;
        sel_vec   = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (grant[i]) begin
                sel_pc    = sel_pc    | src[i].pc;
                sel_cause = sel_cause | src[i].cause;
                sel_vec   = sel_vec   | src[i].vec;
            end
        end
    end
endmodule

// File: rtl/status_merge.sv
module status_merge
    import isr_pkg::*;
(
    input  logic [XLEN-1:0] msr,
    input  logic [XLEN-1:0] cause,
    output logic [XLEN-1:0] status
);
    always_comb begin
        status = msr;
        status[CHI_DST_MSB:CHI_DST_LSB] = cause[CHI_SRC_MSB:CHI_SRC_LSB];
        status[CLO_DST_MSB:CLO_DST_LSB] = cause[CLO_SRC_MSB:CLO_SRC_LSB];
    end
endmodule

// File: rtl/save_bank.sv
module save_bank #(
    parameter  int DEPTH = 5,
    parameter  int W     = 64,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam logic [AW:0] LIMIT = (AW + 1)'(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic         w_ok;
    logic         r_ok;

    assign w_ok = ({1'b0, waddr} < LIMIT);
    assign r_ok = ({1'b0, raddr} < LIMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            rdata <= '0;
        end else begin
            if (we && w_ok) mem[waddr] <= wdata;
            if (we && w_ok && raddr == waddr) rdata <= wdata;
            else if (r_ok)                    rdata <= mem[raddr];
            else                              rdata <= '0;
        end
    end

    // R3
    bypass_new_chk: assert property (@(posedge clk) disable iff (rst)
        (we && w_ok && raddr == waddr) |=> (rdata == $past(wdata)));

    // R5
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (rdata == '0));

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_hold
            // R4
            entry_hold_chk: assert property (@(posedge clk) disable iff (rst)
                !(we && waddr == AW'(i)) |=> $stable(mem[i]));
        end
    endgenerate
endmodule

// File: rtl/save_reg_store.sv
module save_reg_store
    import isr_pkg::*;
#(
    parameter  int DEPTH    = NPAIRS,
    parameter  int SAVE_IDX = IDX_SAVE,
    localparam int AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    wr_addr,
    input  logic             wr_en_even,
    input  logic [XLEN-1:0]  wr_data_even,
    input  logic             wr_en_odd,
    input  logic [XLEN-1:0]  wr_data_odd,
    input  logic [AW-1:0]    rd_addr_even,
    output logic [XLEN-1:0]  rd_data_even,
    input  logic [AW-1:0]    rd_addr_odd,
    output logic [XLEN-1:0]  rd_data_odd,
    input  logic             ex_intr,
    input  logic [XLEN-1:0]  ex_pc,
    input  logic [XLEN-1:0]  ex_cause,
    input  logic [VEC_W-1:0] ex_vec,
    input  logic             ls_intr,
    input  logic [XLEN-1:0]  ls_pc,
    input  logic [XLEN-1:0]  ls_cause,
    input  logic [VEC_W-1:0] ls_vec,
    input  logic             fp_intr,
    input  logic [XLEN-1:0]  fp_pc,
    input  logic [XLEN-1:0]  fp_cause,
    input  logic [VEC_W-1:0] fp_vec,
    input  logic [XLEN-1:0]  cur_msr,
    output logic             intr_taken,
    output logic [VEC_W-1:0] intr_vec
);
    localparam logic [AW-1:0] SAVE_A = AW'(SAVE_IDX);

    isrc_t [NSRC-1:0] src;
    logic  [NSRC-1:0] grant;
    logic  [XLEN-1:0] sel_pc;
    logic  [XLEN-1:0] sel_cause;
    logic  [XLEN-1:0] save_status;

    logic             even_we;
    logic             odd_we;
    logic [AW-1:0]    eff_addr;
    logic [XLEN-1:0]  even_wd;
    logic [XLEN-1:0]  odd_wd;

    assign src[SRC_EX] = '{req: ex_intr, pc: ex_pc, cause: ex_cause, vec: ex_vec};
    assign src[SRC_LS] = '{req: ls_intr, pc: ls_pc, cause: ls_cause, vec: ls_vec};
    assign src[SRC_FP] = '{req: fp_intr, pc: fp_pc, cause: fp_cause, vec: fp_vec};

    intr_arbiter u_arb (
        .src       (src),
        .grant     (grant),
        .any_req   (intr_taken),
        .sel_pc    (sel_pc),
        .sel_cause (sel_cause),
        .sel_vec   (intr_vec)
    );

    status_merge u_merge (
        .msr    (cur_msr),
        .cause  (sel_cause),
        .status (save_status)
    );

    // interrupt commit overrides the normal write path
    always_comb begin
        if (intr_taken) begin
            eff_addr = SAVE_A;
            even_we  = 1'b1;
            odd_we   = 1'b1;
            even_wd  = sel_pc;
            odd_wd   = save_status;
        end else begin
            eff_addr = wr_addr;
            even_we  = wr_en_even;
            odd_we   = wr_en_odd;
            even_wd  = wr_data_even;
            odd_wd   = wr_data_odd;
        end
    end

    save_bank #(.DEPTH(DEPTH), .W(XLEN)) u_even (
        .clk   (clk),
        .rst   (rst),
        .we    (even_we),
        .waddr (eff_addr),
        .wdata (even_wd),
        .raddr (rd_addr_even),
        .rdata (rd_data_even)
    );

    save_bank #(.DEPTH(DEPTH), .W(XLEN)) u_odd (
        .clk   (clk),
        .rst   (rst),
        .we    (odd_we),
        .waddr (eff_addr),
        .wdata (odd_wd),
        .raddr (rd_addr_odd),
        .rdata (rd_data_odd)
    );

    // R8
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R8
    ex_wins_chk: assert property (@(posedge clk) disable iff (rst)
        ex_intr |-> (intr_vec == ex_vec && sel_pc == ex_pc));

    // R6
    save_pc_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (intr_taken && rd_addr_even == SAVE_A) |=> (rd_data_even == $past(sel_pc)));

    // R7
    status_fields_chk: assert property (@(posedge clk) disable iff (rst)
        (intr_taken && rd_addr_odd == SAVE_A) |=>
            (rd_data_odd[21:16] == $past(sel_cause[5:0]) &&
             rd_data_odd[30:27] == $past(sel_cause[14:11]) &&
             rd_data_odd[15:0]  == $past(cur_msr[15:0])));
endmodule

// File: tb/sim_save_reg_store.sv
module sim_save_reg_store;
    localparam int AW = 3;

    typedef struct packed {
        logic [2:0]  req;   // {fp, ls, ex}
        logic [63:0] msr;
        logic [63:0] ce;
        logic [63:0] cl;
        logic [63:0] cf;
    } tv_t;

    localparam int NTV = 6;
    localparam tv_t TV [NTV] = '{
        '{3'b001, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0, 64'h0},
        '{3'b110, 64'h0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0},
        '{3'b100, 64'h0123_4567_89AB_CDEF, 64'h0, 64'h0, 64'h0000_0000_0000_5A2D},
        '{3'b111, 64'hA5A5_5A5A_C3C3_3C3C, 64'h0000_0000_0000_3C15, 64'hFFFF, 64'hFFFF},
        '{3'b000, 64'hDEAD_BEEF_0000_1111, 64'hFFFF, 64'hFFFF, 64'hFFFF},
        '{3'b010, 64'h0F0F_0F0F_F0F0_F0F0, 64'hFFFF, 64'h0000_0000_0000_4821, 64'h0}
    };

    localparam logic [63:0] PC_E = 64'h0000_0000_0000_1000;
    localparam logic [63:0] PC_L = 64'h0000_0000_0000_2004;
    localparam logic [63:0] PC_F = 64'h0000_0000_0000_3008;
    localparam logic [11:0] V_E  = 12'h700;
    localparam logic [11:0] V_L  = 12'h300;
    localparam logic [11:0] V_F  = 12'h800;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] wr_addr, rd_addr_even, rd_addr_odd;
    logic          wr_en_even, wr_en_odd;
    logic [63:0]   wr_data_even, wr_data_odd, rd_data_even, rd_data_odd;
    logic          ex_intr, ls_intr, fp_intr, intr_taken;
    logic [63:0]   ex_cause, ls_cause, fp_cause, cur_msr;
    logic [11:0]   intr_vec;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    save_reg_store u0 (
        .clk(clk), .rst(rst), .wr_addr(wr_addr),
        .wr_en_even(wr_en_even), .wr_data_even(wr_data_even),
        .wr_en_odd(wr_en_odd), .wr_data_odd(wr_data_odd),
        .rd_addr_even(rd_addr_even), .rd_data_even(rd_data_even),
        .rd_addr_odd(rd_addr_odd), .rd_data_odd(rd_data_odd),
        .ex_intr(ex_intr), .ex_pc(PC_E), .ex_cause(ex_cause), .ex_vec(V_E),
        .ls_intr(ls_intr), .ls_pc(PC_L), .ls_cause(ls_cause), .ls_vec(V_L),
        .fp_intr(fp_intr), .fp_pc(PC_F), .fp_cause(fp_cause), .fp_vec(V_F),
        .cur_msr(cur_msr), .intr_taken(intr_taken), .intr_vec(intr_vec)
    );

    function automatic logic [63:0] model_status(input logic [63:0] m, input logic [63:0] c);
        return (m & 64'hFFFF_FFFF_87C0_FFFF)
             | ({60'b0, c[14:11]} << 27)
             | ({58'b0, c[5:0]}   << 16);
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        wr_en_even = 1'b0; wr_en_odd = 1'b0;
        ex_intr = 1'b0; ls_intr = 1'b0; fp_intr = 1'b0;
    endtask

    task automatic pair_write(input logic [AW-1:0] a, input logic [63:0] de, input logic [63:0] d_o);
        wr_addr = a; wr_en_even = 1'b1; wr_en_odd = 1'b1;
        wr_data_even = de; wr_data_odd = d_o;
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [63:0] exp_e, exp_o;
        rst = 1'b1;
        wr_addr = '0; rd_addr_even = '0; rd_addr_odd = '0;
        wr_data_even = '0; wr_data_odd = '0;
        ex_cause = '0; ls_cause = '0; fp_cause = '0; cur_msr = '0;
        idle();
        @(negedge clk);
        step();
        rst = 1'b0;
        chk("R5 reset even", rd_data_even, 64'h0);
        chk("R5 reset odd", rd_data_odd, 64'h0);

        // table walk: R6 R7 R8
        exp_e = '0; exp_o = '0;
        rd_addr_even = 3'd0; rd_addr_odd = 3'd0;
        for (int k = 0; k < NTV; k++) begin
            logic [11:0] ev;
            idle();
            ex_intr = TV[k].req[0]; ls_intr = TV[k].req[1]; fp_intr = TV[k].req[2];
            ex_cause = TV[k].ce; ls_cause = TV[k].cl; fp_cause = TV[k].cf;
            cur_msr = TV[k].msr;
            if (TV[k].req[0]) begin
                ev = V_E; exp_e = PC_E; exp_o = model_status(TV[k].msr, TV[k].ce);
            end else if (TV[k].req[1]) begin
                ev = V_L; exp_e = PC_L; exp_o = model_status(TV[k].msr, TV[k].cl);
            end else if (TV[k].req[2]) begin
                ev = V_F; exp_e = PC_F; exp_o = model_status(TV[k].msr, TV[k].cf);
            end else begin
                ev = 12'h0;
            end
            #1;
            chk("R8 taken", {63'b0, intr_taken}, {63'b0, |TV[k].req});
            chk("R8 vector", {52'b0, intr_vec}, {52'b0, ev});
            step();
            chk("R6 save pc", rd_data_even, exp_e);
            chk("R7 status merge", rd_data_odd, exp_o);
        end
        idle();

        // R1: pair write at index 2, read back next cycle
        rd_addr_even = 3'd1; rd_addr_odd = 3'd1;
        pair_write(3'd2, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888);
        step();
        idle();
        chk("R4 idx1 even untouched", rd_data_even, 64'h0);
        rd_addr_even = 3'd2; rd_addr_odd = 3'd2;
        step();
        chk("R1 pair even", rd_data_even, 64'h1111_2222_3333_4444);
        chk("R1 pair odd", rd_data_odd, 64'h5555_6666_7777_8888);

        // R3: write index 3 while reading it
        pair_write(3'd3, 64'hAAAA_0000_0000_0003, 64'hBBBB_0000_0000_0003);
        rd_addr_even = 3'd3; rd_addr_odd = 3'd3;
        step();
        idle();
        chk("R3 bypass even", rd_data_even, 64'hAAAA_0000_0000_0003);
        chk("R3 bypass odd", rd_data_odd, 64'hBBBB_0000_0000_0003);

        // R2: independent addresses and registered timing
        rd_addr_even = 3'd2; rd_addr_odd = 3'd3;
        #1;
        chk("R2 no change before edge", rd_data_even, 64'hAAAA_0000_0000_0003);
        step();
        chk("R2 even at idx2", rd_data_even, 64'h1111_2222_3333_4444);
        chk("R2 odd at idx3", rd_data_odd, 64'hBBBB_0000_0000_0003);

        // R4: even only at index 4
        wr_addr = 3'd4; wr_en_even = 1'b1; wr_en_odd = 1'b0;
        wr_data_even = 64'hC0DE_0000_0000_0004; wr_data_odd = 64'hBAD0_0000_0000_0004;
        rd_addr_even = 3'd0; rd_addr_odd = 3'd0;
        step();
        idle();
        rd_addr_even = 3'd4; rd_addr_odd = 3'd4;
        step();
        chk("R4 even written", rd_data_even, 64'hC0DE_0000_0000_0004);
        chk("R4 odd disabled", rd_data_odd, 64'h0);

        // R9: interrupt collides with a normal write to index 1
        pair_write(3'd1, 64'hFEED_0000_0000_0001, 64'hFACE_0000_0000_0001);
        ex_intr = 1'b1; ex_cause = 64'h0000_0000_0000_783F; cur_msr = 64'h0;
        rd_addr_even = 3'd2; rd_addr_odd = 3'd2;
        step();
        idle();
        rd_addr_even = 3'd1; rd_addr_odd = 3'd0;
        step();
        chk("R9 normal write dropped", rd_data_even, 64'h0);
        chk("R9 interrupt status kept", rd_data_odd, model_status(64'h0, 64'h783F));

        // R5: reset mid-run clears stored pairs
        rst = 1'b1;
        step();
        rst = 1'b0;
        rd_addr_even = 3'd2; rd_addr_odd = 3'd2;
        step();
        chk("R5 cleared even", rd_data_even, 64'h0);
        chk("R5 cleared odd", rd_data_odd, 64'h0);

        summary();
        $finish;
    end
endmodule